// File: doc/BRIEF.md
# Composite Sync and Burst Gate

This block sits at the timing front end of a colour video encoder and runs on the clock at four times the colour subcarrier. It takes active-low horizontal and vertical sync inputs, moves them into its clock domain, and merges them into one active-low composite sync by XNOR. A source that already supplies composite sync drives it on the horizontal input and ties the vertical input high. The composite sync then passes straight through.

Falling edges of the composite sync are qualified as true line syncs with a spacing rule. The half-line equalizing and serration pulses of the vertical interval are rejected this way. Each qualified sync arms a back-porch window. The window opens a programmable number of cycles after the sync's trailing edge and lasts a programmable number of cycles. The same window drives the input clamp and burst insertion. Burst enables are issued for the U channel always, and for the V channel only in PAL mode.

Top module: `csync_burst_gate`

## Requirements
- R1: `csync_o` equals the XNOR of `hsync_ni` and `vsync_ni` as sampled two clock edges earlier (two-flop synchronizer on each input, both reset to 1).
- R2: While `vsync_ni` is held at 1, `csync_o` reproduces `hsync_ni` unchanged with a two-cycle delay.
- R3: The first falling edge of `csync_o` after reset only sets the timing reference. It yields no `hsync_valid_o` pulse and no burst window.
- R4: A later falling edge of `csync_o` is a valid line sync only if it comes at least ACCEPT_CYCLES (LINE_CYCLES*ACCEPT_PCT/100) cycles after the last reference or valid edge. Rejected edges do not move the reference. Each valid edge gives a one-cycle `hsync_valid_o` pulse in the following cycle.
- R5: Two `hsync_valid_o` pulses are never closer than ACCEPT_CYCLES cycles.
- R6: After a valid sync, let r be the first cycle in which `csync_o` is high again. `burst_gate_o` is then high from cycle r+BURST_DELAY+1 for exactly BURST_LEN cycles.
- R7: If the synchronized vertical sync is low in a cycle, `burst_gate_o` is low in the next cycle and any pending or open window is dropped.
- R8: A new valid sync while a window is pending or open restarts the sequence, and `burst_gate_o` is low from the next cycle.
- R9: `burst_u_o` equals `burst_gate_o`. `burst_v_o` equals `burst_gate_o` when `pal_mode_i` is 1 and is 0 when it is 0.
- R10: During reset `csync_o` is 1 and `hsync_valid_o`, `burst_gate_o`, `burst_u_o` and `burst_v_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at four times subcarrier frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync or composite sync, active low |
| vsync_ni | input | 1 | Vertical sync, active low; tie high for composite input |
| pal_mode_i | input | 1 | 1 selects PAL burst on both channels, 0 selects NTSC |
| csync_o | output | 1 | Composite sync, active low |
| hsync_valid_o | output | 1 | One-cycle pulse per qualified line sync |
| burst_gate_o | output | 1 | Back-porch window for clamp and burst |
| burst_u_o | output | 1 | Burst enable for the U channel |
| burst_v_o | output | 1 | Burst enable for the V channel |

## Verification
The assertions check these rules on every cycle: the XNOR with its two-cycle latency, that every `hsync_valid_o` follows a falling edge, the minimum spacing between valid pulses, the upper bound on window length, window suppression during vertical sync, and the gating of the channel enables. The exact position of each window, the cut-short windows on restart, the equalizing-pulse rejection count, the exact acceptance boundary and the behaviour after a reset in mid-window are shown only by the bench scenarios. There, a behavioural timestamp model predicts every output on every clock.

// File: rtl/csbg_pkg.sv
package csbg_pkg;
  typedef enum logic [1:0] {
    BW_IDLE,
    BW_WAIT_TRAIL,
    BW_DELAY,
    BW_GATE
  } bw_state_e;
endpackage

// File: rtl/csbg_sync.sv
module csbg_sync #(
  parameter int unsigned W         = 2,
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= {STAGES{RESET_VAL}};
      else         st_q <= {st_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = st_q[STAGES-1];
  end
endmodule

// File: rtl/csbg_hqual.sv
module csbg_hqual #(
  parameter int unsigned ACCEPT_CYCLES = 728
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_i,
  output logic accept_o,
  output logic trail_o,
  output logic valid_o
);
  localparam int unsigned    CW  = $clog2(ACCEPT_CYCLES + 1);
  localparam logic [CW-1:0] ACC = CW'(ACCEPT_CYCLES);

  logic          csync_q, armed_q, valid_q, fall;
  logic [CW-1:0] since_q;

  assign fall     = csync_q & ~csync_i;
  assign trail_o  = ~csync_q & csync_i;
  assign accept_o = fall & armed_q & (since_q == ACC);
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csync_q <= 1'b1;
      armed_q <= 1'b0;
      since_q <= '0;
      valid_q <= 1'b0;
    end else begin
      csync_q <= csync_i;
      valid_q <= accept_o;
      if (fall && !armed_q) begin
        armed_q <= 1'b1;
        since_q <= CW'(1);
      end else if (accept_o) begin
        since_q <= CW'(1);
      end else if (armed_q && since_q != ACC) begin
        since_q <= since_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/csbg_burst_win.sv
module csbg_burst_win
  import csbg_pkg::*;
#(
  parameter int unsigned BURST_DELAY = 19,
  parameter int unsigned BURST_LEN   = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic trail_i,
  input  logic vblank_i,
  output logic gate_o
);
  localparam int unsigned MAXC = (BURST_DELAY > BURST_LEN) ? BURST_DELAY : BURST_LEN;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_END = CW'(BURST_DELAY - 1);
  localparam logic [CW-1:0] LEN_END = CW'(BURST_LEN - 1);

  bw_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BW_IDLE;
      cnt_q   <= '0;
    end else if (vblank_i) begin
      state_q <= BW_IDLE;
      cnt_q   <= '0;
    end else if (accept_i) begin
      state_q <= BW_WAIT_TRAIL;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        BW_WAIT_TRAIL: if (trail_i) state_q <= BW_DELAY;
        BW_DELAY: begin
          if (cnt_q == DLY_END) begin
            state_q <= BW_GATE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        BW_GATE: begin
          if (cnt_q == LEN_END) begin
            state_q <= BW_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: state_q <= BW_IDLE;
      endcase
    end
  end

  assign gate_o = (state_q == BW_GATE);
endmodule

// File: rtl/csync_burst_gate.sv
module csync_burst_gate #(
  parameter int unsigned LINE_CYCLES = 910,
  parameter int unsigned ACCEPT_PCT  = 80,
  parameter int unsigned BURST_DELAY = 19,
  parameter int unsigned BURST_LEN   = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_ni,
  input  logic vsync_ni,
  input  logic pal_mode_i,
  output logic csync_o,
  output logic hsync_valid_o,
  output logic burst_gate_o,
  output logic burst_u_o,
  output logic burst_v_o
);
  localparam int unsigned ACCEPT_CYCLES = LINE_CYCLES * ACCEPT_PCT / 100;

  logic [1:0] sync_s;
  logic       h_s, v_s, accept, trail, gate;

  csbg_sync #(.W(2), .STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hsync_ni, vsync_ni}),
    .q_o   (sync_s)
  );

  assign h_s     = sync_s[1];
  assign v_s     = sync_s[0];
  assign csync_o = ~(h_s ^ v_s);

  csbg_hqual #(.ACCEPT_CYCLES(ACCEPT_CYCLES)) u_hqual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .csync_i (csync_o),
    .accept_o(accept),
    .trail_o (trail),
    .valid_o (hsync_valid_o)
  );

  csbg_burst_win #(.BURST_DELAY(BURST_DELAY), .BURST_LEN(BURST_LEN)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .trail_i (trail),
    .vblank_i(~v_s),
    .gate_o  (gate)
  );

  assign burst_gate_o = gate;
  assign burst_u_o    = gate;
  assign burst_v_o    = gate & pal_mode_i;
endmodule

// File: rtl/csync_burst_gate_chk.sv
module csync_burst_gate_chk #(
  parameter int unsigned ACCEPT_CYCLES = 728,
  parameter int unsigned BURST_LEN     = 36
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hsync_ni,
  input logic vsync_ni,
  input logic pal_mode_i,
  input logic csync_o,
  input logic hsync_valid_o,
  input logic burst_gate_o,
  input logic burst_u_o,
  input logic burst_v_o
);
  localparam int unsigned    GW  = $clog2(ACCEPT_CYCLES + 1);
  localparam logic [GW-1:0] ACC = GW'(ACCEPT_CYCLES);
  localparam int unsigned    RW  = $clog2(BURST_LEN + 2);

  logic [1:0]    age_q;
  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (hsync_valid_o) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q != ACC) gap_q <= gap_q + GW'(1);
      if (burst_gate_o && run_q != RW'(BURST_LEN + 1)) run_q <= run_q + RW'(1);
      else if (!burst_gate_o) run_q <= '0;
    end
  end

  a_r1_csync_xnor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (csync_o == ($past(hsync_ni, 2) ~^ $past(vsync_ni, 2))));

  a_r4_valid_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && hsync_valid_o) |-> (!$past(csync_o) && $past(csync_o, 2)));

  a_r5_valid_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_valid_o && seen_q) |-> (gap_q >= ACC));

  a_r6_gate_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_gate_o |-> (run_q < RW'(BURST_LEN)));

  a_r7_vsync_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && !$past(vsync_ni, 2)) |=> !burst_gate_o);

  a_r9_u_with_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_u_o |-> burst_gate_o);

  a_r9_v_needs_pal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_v_o |-> (pal_mode_i && burst_u_o));
endmodule

bind csync_burst_gate csync_burst_gate_chk #(
  .ACCEPT_CYCLES(ACCEPT_CYCLES),
  .BURST_LEN    (BURST_LEN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hsync_ni     (hsync_ni),
  .vsync_ni     (vsync_ni),
  .pal_mode_i   (pal_mode_i),
  .csync_o      (csync_o),
  .hsync_valid_o(hsync_valid_o),
  .burst_gate_o (burst_gate_o),
  .burst_u_o    (burst_u_o),
  .burst_v_o    (burst_v_o)
);

// File: tb/csync_burst_gate_bench.sv
module csync_burst_gate_bench;
  localparam int LINE = 120;
  localparam int ACC  = 96;
  localparam int DLY  = 5;
  localparam int LEN  = 12;

  logic clk = 1'b0, rst_n = 1'b0, hs = 1'b1, vs = 1'b1, pal = 1'b0;
  logic csync, hvalid, gate, bu, bv;

  always #4 clk = ~clk;

  csync_burst_gate #(.LINE_CYCLES(LINE), .ACCEPT_PCT(80), .BURST_DELAY(DLY), .BURST_LEN(LEN))
  u_csync_burst_gate (
    .clk_i(clk), .rst_ni(rst_n), .hsync_ni(hs), .vsync_ni(vs), .pal_mode_i(pal),
    .csync_o(csync), .hsync_valid_o(hvalid), .burst_gate_o(gate),
    .burst_u_o(bu), .burst_v_o(bv)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int n_valid = 0, n_gate = 0, n_u = 0, n_v = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // timestamp reference model
  bit h1 = 1, h2 = 1, v1 = 1, v2 = 1, cq = 1, armed = 0, pend = 0;
  bit e_c = 1, e_valid = 0, e_gate = 0;
  int cyc = 0, last_acc = 0, gs = -10, ge = -20;

  always @(posedge clk) begin
    bit c, fall, rise, acc;
    if (!rst_n) begin
      h1 = 1; h2 = 1; v1 = 1; v2 = 1; cq = 1; armed = 0; pend = 0;
      e_c = 1; e_valid = 0; e_gate = 0; gs = -10; ge = -20;
    end else begin
      c    = ~(h2 ^ v2);
      fall = cq & ~c;
      rise = ~cq & c;
      acc  = fall && armed && (cyc - last_acc >= ACC);
      if (fall && !armed) begin armed = 1; last_acc = cyc; end
      if (acc) last_acc = cyc;
      if (!v2) begin pend = 0; gs = -10; ge = -20; end
      else if (acc) begin pend = 1; gs = -10; ge = -20; end
      else if (pend && rise) begin pend = 0; gs = cyc + DLY + 1; ge = gs + LEN - 1; end
      e_valid = acc;
      cq = c;
      h2 = h1; h1 = hs; v2 = v1; v1 = vs;
      e_c    = ~(h2 ^ v2);
      e_gate = (cyc + 1 >= gs) && (cyc + 1 <= ge);
    end
    cyc++;
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(csync == e_c, "R1 R2 csync", csync, e_c);
      check(hvalid == e_valid, "R3 R4 hsync_valid", hvalid, e_valid);
      check(gate == e_gate, "R6 R7 R8 burst_gate", gate, e_gate);
      check(bu == e_gate, "R9 burst_u", bu, e_gate);
      check(bv == (e_gate & pal), "R9 burst_v", bv, e_gate & pal);
      n_valid += hvalid;
      n_gate  += gate;
      n_u     += bu;
      n_v     += bv;
    end
  end

  task automatic line(input int w, input int p);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      hs = (i < w) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic clr();
    n_valid = 0; n_gate = 0; n_u = 0; n_v = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csync == 1'b1, "R10 reset csync", csync, 1);
    check({hvalid, gate, bu, bv} == 4'b0, "R10 reset outputs", {hvalid, gate, bu, bv}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // composite input with equalizing pulses
    clr();
    line(10, LINE); line(10, LINE);
    for (int k = 0; k < 8; k++) line(4, LINE / 2);
    line(10, LINE); line(10, LINE);
    repeat (40) @(negedge clk);
    check(n_valid == 7, "R4 equalizing rejection valid count", n_valid, 7);
    check(n_gate == 7 * LEN, "R6 window cycles", n_gate, 7 * LEN);
    check(n_v == 0, "R9 ntsc no V burst", n_v, 0);

    // PAL
    pal = 1'b1;
    clr();
    line(10, LINE); line(10, LINE); line(10, LINE);
    check(n_valid == 3, "R4 pal valid count", n_valid, 3);
    check(n_u == 3 * LEN, "R9 pal U burst", n_u, 3 * LEN);
    check(n_v == 3 * LEN, "R9 pal V burst", n_v, 3 * LEN);
    pal = 1'b0;

    // acceptance boundary
    clr();
    line(10, ACC); line(10, ACC - 1); line(10, LINE); line(10, LINE);
    check(n_valid == 3, "R4 boundary valid count", n_valid, 3);

    // separate syncs with vertical sync active
    line(10, LINE);
    vs = 1'b0;
    clr();
    line(10, LINE); line(10, LINE); line(10, LINE);
    check(n_gate == 0, "R7 no window during vsync", n_gate, 0);
    vs = 1'b1;
    line(10, LINE); line(10, LINE); line(10, LINE);

    // restart while window open
    clr();
    line(105, LINE); line(105, LINE); line(105, LINE);
    repeat (LINE) @(negedge clk);
    check(n_valid == 3, "R8 restart valid count", n_valid, 3);
    check(n_gate == 2 * (LEN - 2) + LEN, "R8 truncated windows", n_gate, 2 * (LEN - 2) + LEN);

    // reset in mid window
    line(10, 25);
    rst_n = 1'b0;
    @(negedge clk);
    check(gate == 1'b0, "R10 gate cleared by reset", gate, 0);
    check(csync == 1'b1, "R10 csync in reset", csync, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clr();
    line(10, LINE);
    check(n_valid == 0, "R3 first edge only arms", n_valid, 0);
    check(n_gate == 0, "R3 no window after first edge", n_gate, 0);
    line(10, LINE); line(10, LINE);
    check(n_valid == 2, "R3 later edges valid", n_valid, 2);
    check(n_gate == 2 * LEN, "R6 windows after rearm", n_gate, 2 * LEN);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule